// File: doc/BRIEF.md
# Burst ROM Read Controller

This block sits on the bus side of an asynchronous ROM and turns one read request into a burst of fixed length. A request carries a start address, a tag that marks it as a DMA transfer, and two wait counts: one for the first beat and one for each later beat. The controller raises chip select and the read strobe and holds both for the whole burst. It steps the address by the bus width at each new beat and returns every captured ROM word with a one-cycle valid pulse.

Each burst opens with a setup cycle and the first-beat wait cycles. Every later beat has a burst cycle and then its own burst-wait cycles. A closing cycle ends the burst. A bus-start strobe marks the first cycle of every beat. An external wait input can hold the last cycle of any beat for as long as it stays high. A done pulse follows the closing cycle, and the controller is then idle again with all strobes low.

With the defaults (32-bit data, 4 beats), one burst moves a 16-byte block. The low four address bits wrap inside that block.

Top module: `brom_burst_rd`

## Requirements
- R1: While reset is held and after its release with no request, cs_o, rd_o, bs_o, ack_o, data_vld_o and done_o are all 0.
- R2: cs_o and rd_o rise in the cycle after the edge that accepts a request. Both stay 1 without a gap for 2 + first_wait + (BEATS-1)*(1+next_wait) cycles, plus any cycles added by wait_i.
- R3: bs_o is 1 exactly in the first cycle of each beat (the setup cycle and each burst cycle) and 0 in every other cycle.
- R4: The first beat lasts 1 + first_wait_i cycles and each later beat lasts 1 + next_wait_i cycles. A wait count of 0 gives a one-cycle beat.
- R5: wait_i is sampled only in the last cycle of a beat. There, a 1 holds that cycle for one more clock. A 1 in any other cycle of the burst has no effect on timing.
- R6: In the first beat, addr_o equals addr_i. At each new beat, bits [3:0] (the block offset, BEATS*bytes wide) increase by 4 modulo 16 while the upper bits stay the same. addr_o does not change inside a beat.
- R7: rom_data_i is captured at the end of the last cycle of each beat. data_vld_o is 1 for exactly the next cycle, with the captured word on data_o. Each burst gives exactly BEATS pulses.
- R8: ack_o is 1 in every cycle of a burst whose request had dma_i = 1, and 0 at all other times.
- R9: done_o is a one-cycle pulse in the cycle after the closing cycle, with cs_o, rd_o and bs_o already 0. After it the controller accepts a new request.
- R10: The wait counts and the DMA tag are taken at the edge that accepts the request. Changing those inputs during the burst has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst read request, taken when idle |
| addr_i | input | ADDR_W | Start byte address |
| dma_i | input | 1 | Marks the request as a DMA transfer |
| first_wait_i | input | WAIT_W | Wait cycles for the first beat |
| next_wait_i | input | WAIT_W | Wait cycles for each later beat |
| wait_i | input | 1 | External wait, active high |
| rom_data_i | input | DATA_W | Data from the ROM |
| cs_o | output | 1 | Chip select, active high |
| rd_o | output | 1 | Read strobe, active high |
| bs_o | output | 1 | Bus-start strobe for each beat |
| addr_o | output | ADDR_W | ROM address |
| ack_o | output | 1 | DMA acknowledge for the burst |
| data_o | output | DATA_W | Last captured word |
| data_vld_o | output | 1 | data_o valid pulse |
| done_o | output | 1 | Burst complete pulse |

## Verification
cs_o rises one cycle after the accepting edge. Cycle indices inside a burst are counted from that first cs_o cycle. With no added waits, beat k ends at index first_wait + k*(1+next_wait). Its valid pulse is due one index later, and done_o one index after the closing cycle. The bench samples at the falling clock edge and records, per index, where bs_o and data_vld_o are high and the address at each bus start. It drives wait_i for chosen indices and compares the recorded positions with masks worked out by hand for each scenario.

// File: rtl/brom_pkg.sv
package brom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,  // first cycle of beat 0
    ST_FWAIT,  // first-beat waits
    ST_BURST,  // first cycle of a later beat
    ST_BWAIT,  // later-beat waits
    ST_CLOSE
  } brom_state_e;
endpackage

// File: rtl/brom_seq.sv
module brom_seq
  import brom_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BEATS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dma_i,
  input  logic [WAIT_W-1:0] first_wait_i,
  input  logic [WAIT_W-1:0] next_wait_i,
  input  logic              wait_i,
  output logic              accept_o,
  output logic              advance_o,
  output logic              capture_o,
  output logic              cs_o,
  output logic              rd_o,
  output logic              bs_o,
  output logic              ack_o,
  output logic              done_o
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  brom_state_e       state_q;
  logic [WAIT_W-1:0] w0_q, w1_q, cnt_q, cur_w;
  logic [BEAT_W-1:0] beat_q;
  logic              dma_q, done_q;
  logic              in_start, in_wait, last_beat, beat_end;

  always_comb begin
    in_start  = (state_q == ST_SETUP) || (state_q == ST_BURST);
    in_wait   = (state_q == ST_FWAIT) || (state_q == ST_BWAIT);
    cur_w     = (state_q == ST_SETUP) ? w0_q : w1_q;
    last_beat = (beat_q == BEAT_W'(BEATS - 1));
    // ext wait only matters on the final cycle of a beat
    beat_end  = !wait_i && ((in_start && (cur_w == '0)) ||
                            (in_wait && (cnt_q == WAIT_W'(1))));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      w0_q    <= '0;
      w1_q    <= '0;
      cnt_q   <= '0;
      beat_q  <= '0;
      dma_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            state_q <= ST_SETUP;
            w0_q    <= first_wait_i;
            w1_q    <= next_wait_i;
            dma_q   <= dma_i;
            beat_q  <= '0;
          end
        end
        ST_SETUP, ST_BURST, ST_FWAIT, ST_BWAIT: begin
          if (beat_end) begin
            if (last_beat) begin
              state_q <= ST_CLOSE;
            end else begin
              state_q <= ST_BURST;
              beat_q  <= beat_q + BEAT_W'(1);
            end
          end else if (in_start) begin
            state_q <= (state_q == ST_SETUP) ? ST_FWAIT : ST_BWAIT;
            cnt_q   <= (cur_w == '0) ? WAIT_W'(1) : cur_w;
          end else if (cnt_q > WAIT_W'(1)) begin
            cnt_q <= cnt_q - WAIT_W'(1);
          end
        end
        ST_CLOSE: begin
          state_q <= ST_IDLE;
          dma_q   <= 1'b0;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign advance_o = beat_end && !last_beat;
  assign capture_o = beat_end;
  assign cs_o      = (state_q != ST_IDLE);
  assign rd_o      = (state_q != ST_IDLE);
  assign bs_o      = in_start;
  assign ack_o     = (state_q != ST_IDLE) && dma_q;
  assign done_o    = done_q;
endmodule

// File: rtl/brom_addr_gen.sv
module brom_addr_gen #(
  parameter int ADDR_W = 26,
  parameter int BLK_W  = 4,
  parameter int STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  generate
    if (BLK_W > 0) begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q <= '0;
        end else if (load_i) begin
          addr_q <= addr_i;
        end else if (step_i) begin
          // offset wraps inside the burst block, upper bits held
          addr_q[BLK_W-1:0] <= addr_q[BLK_W-1:0] + BLK_W'(STEP);
        end
      end
    end else begin : g_fixed
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) addr_q <= '0;
        else if (load_i) addr_q <= addr_i;
      end
    end
  endgenerate

  assign addr_o = addr_q;
endmodule

// File: rtl/brom_capture.sv
module brom_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= capture_i;
      if (capture_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/brom_burst_rd.sv
module brom_burst_rd #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dma_i,
  input  logic [WAIT_W-1:0] first_wait_i,
  input  logic [WAIT_W-1:0] next_wait_i,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              cs_o,
  output logic              rd_o,
  output logic              bs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_vld_o,
  output logic              done_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int BLK_W = $clog2(BEATS * BYTES);

  logic accept, advance, capture;

  brom_seq #(.WAIT_W(WAIT_W), .BEATS(BEATS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .dma_i        (dma_i),
    .first_wait_i (first_wait_i),
    .next_wait_i  (next_wait_i),
    .wait_i       (wait_i),
    .accept_o     (accept),
    .advance_o    (advance),
    .capture_o    (capture),
    .cs_o         (cs_o),
    .rd_o         (rd_o),
    .bs_o         (bs_o),
    .ack_o        (ack_o),
    .done_o       (done_o)
  );

  brom_addr_gen #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .STEP(BYTES)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .addr_i (addr_i),
    .step_i (advance),
    .addr_o (addr_o)
  );

  brom_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .data_i    (rom_data_i),
    .data_o    (data_o),
    .vld_o     (data_vld_o)
  );
endmodule

// File: rtl/brom_burst_rd_chk.sv
module brom_burst_rd_chk #(
  parameter int ADDR_W = 26,
  parameter int BLK_W  = 4,
  parameter int STEP   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_o,
  input logic              rd_o,
  input logic              bs_o,
  input logic              ack_o,
  input logic              data_vld_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o
);
  // R2
  rd_with_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o == cs_o);
  // R2
  cs_fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o);
  // R3
  bs_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> bs_o);
  // R3
  bs_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_o |-> cs_o);
  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && !bs_o) |-> $stable(addr_o));
  // R6
  addr_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bs_o && $past(cs_o)) |-> (addr_o[ADDR_W-1:BLK_W] == $past(addr_o[ADDR_W-1:BLK_W])));
  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bs_o && $past(cs_o)) |-> (addr_o[BLK_W-1:0] == $past(addr_o[BLK_W-1:0]) + BLK_W'(STEP)));
  // R7
  vld_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> cs_o);
  // R8
  ack_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cs_o);
  // R8
  ack_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o)) |-> $stable(ack_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cs_o && !bs_o));
endmodule

bind brom_burst_rd brom_burst_rd_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .STEP(BYTES)) u_chk (.*);

// File: tb/tb_brom_burst_rd.sv
`timescale 1ns/1ps
module tb_brom_burst_rd;
  localparam int AW = 26;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          dma_i = 1'b0;
  logic [WW-1:0] first_wait_i = '0;
  logic [WW-1:0] next_wait_i = '0;
  logic          wait_i = 1'b0;
  logic [DW-1:0] rom_data_i;
  logic          cs_o, rd_o, bs_o, ack_o, data_vld_o, done_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;

  always #10 clk_i = ~clk_i;

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    return 32'h9E37_0000 ^ {6'd0, a};
  endfunction

  assign rom_data_i = rom_word(addr_o);

  brom_burst_rd dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // burst monitor, indices count from first cs_o cycle
  bit            mon_on = 0, exp_ack = 0, done_seen = 0;
  int            cyc = 0, nb = 0, nv = 0, done_at = 0;
  int            ack_bad = 0, rd_bad = 0, idle_bad = 0;
  logic [63:0]   wait_mask = '0, bs_mask = '0, vld_mask = '0;
  logic [AW-1:0] bs_addr [4];
  logic [DW-1:0] vld_data [4];

  always @(negedge clk_i) begin
    if (mon_on) begin
      if (cs_o) begin
        wait_i = (cyc < 64) ? wait_mask[cyc] : 1'b0;
        if (bs_o) begin
          if (cyc < 64) bs_mask[cyc] = 1'b1;
          if (nb < 4) bs_addr[nb] = addr_o;
          nb++;
        end
        if (data_vld_o) begin
          if (cyc < 64) vld_mask[cyc] = 1'b1;
          if (nv < 4) vld_data[nv] = data_o;
          nv++;
        end
        if (rd_o !== 1'b1) rd_bad++;
        if (ack_o !== exp_ack) ack_bad++;
        cyc++;
      end else begin
        wait_i = 1'b0;
        if (rd_o || bs_o || ack_o || data_vld_o) idle_bad++;
        if (done_o && !done_seen) begin
          done_seen = 1;
          done_at = cyc;
        end
      end
    end
  end

  task automatic run_burst(input string name, input logic [AW-1:0] a,
                           input int w0, input int w1, input bit dma,
                           input logic [63:0] wmask, input int exp_len,
                           input logic [63:0] exp_bs, input logic [63:0] exp_vld);
    logic [AW-1:0] ea;
    @(negedge clk_i);
    cyc = 0; nb = 0; nv = 0; done_at = 0; done_seen = 0;
    ack_bad = 0; rd_bad = 0; idle_bad = 0;
    bs_mask = '0; vld_mask = '0; wait_mask = wmask; exp_ack = dma;
    mon_on = 1;
    req_i = 1'b1; addr_i = a; dma_i = dma;
    first_wait_i = WW'(w0); next_wait_i = WW'(w1);
    @(negedge clk_i);
    req_i = 1'b0; addr_i = ~a;
    // R10: disturb config after acceptance
    first_wait_i = WW'(7); next_wait_i = WW'(7); dma_i = ~dma;
    for (int i = 0; i < 200 && !done_seen; i++) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_seen, "R9", {name, " done seen"}, 64'(done_seen), 64'd1);
    chk(!done_o, "R9", {name, " done one cycle"}, 64'(done_o), 64'd0);
    chk(done_at == exp_len, "R2", {name, " cs length"}, 64'(done_at), 64'(exp_len));
    chk(rd_bad == 0, "R2", {name, " rd gaps"}, 64'(rd_bad), 64'd0);
    chk(bs_mask == exp_bs, "R3", {name, " bs positions"}, bs_mask, exp_bs);
    chk(vld_mask == exp_vld, "R4", {name, " beat ends/R5 wait"}, vld_mask, exp_vld);
    chk(nv == 4, "R7", {name, " vld count"}, 64'(nv), 64'd4);
    chk(ack_bad == 0, "R8", {name, " ack level"}, 64'(ack_bad), 64'd0);
    chk(idle_bad == 0, "R9", {name, " strobes idle"}, 64'(idle_bad), 64'd0);
    for (int k = 0; k < 4; k++) begin
      ea = {a[AW-1:4], 4'(a[3:0] + 4'(4 * k))};
      chk(bs_addr[k] == ea, "R6", {name, " beat addr"}, 64'(bs_addr[k]), 64'(ea));
      chk(vld_data[k] == rom_word(ea), "R7", {name, " beat data"},
          64'(vld_data[k]), 64'(rom_word(ea)));
    end
    mon_on = 0;
    dma_i = 1'b0;
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk_i);
    chk({cs_o, rd_o, bs_o, ack_o, data_vld_o, done_o} == 6'b0, "R1", "in reset",
        64'({cs_o, rd_o, bs_o, ack_o, data_vld_o, done_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({cs_o, rd_o, bs_o, ack_o, data_vld_o, done_o} == 6'b0, "R1", "after reset",
        64'({cs_o, rd_o, bs_o, ack_o, data_vld_o, done_o}), 64'd0);
  endtask

  // R4: w0=2, w1=1 -> beat ends 2,4,6,8
  task automatic t_basic;
    run_burst("basic", 26'h100, 2, 1, 0, 64'h0, 10, 64'h0A9, 64'h2A8);
  endtask
  // R6: offset 8 wraps; R8 dma tag
  task automatic t_wrap_dma;
    run_burst("wrap", 26'h2008, 1, 0, 1, 64'h0, 6, 64'h01D, 64'h03C);
  endtask
  task automatic t_zero_wait;
    run_burst("zero", 26'h3FF_FFF0, 0, 0, 0, 64'h0, 5, 64'h00F, 64'h01E);
  endtask
  // R5: wait high at idx 2,3 (last cycle of beat 0) adds 2 cycles
  task automatic t_stretch;
    run_burst("stretch", 26'h0440, 2, 1, 1, 64'h00C, 12, 64'h2A1, 64'hAA0);
  endtask
  // R5: wait at idx 1 (early Tw) and idx 3 (burst cycle w1=1) ignored
  task automatic t_ignored;
    run_burst("ignored", 26'h100, 2, 1, 0, 64'h00A, 10, 64'h0A9, 64'h2A8);
  endtask
  // R5: zero-wait burst cycle at idx 2 held one extra cycle
  task automatic t_zero_stretch;
    run_burst("zstretch", 26'h0004, 0, 0, 0, 64'h004, 6, 64'h017, 64'h036);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap_dma();
    t_zero_wait();
    t_stretch();
    t_ignored();
    t_zero_stretch();
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule